// File: doc/BRIEF.md
# Random Number Generator Register Block

This block is the 32-bit memory-mapped register slave that sits between a processor bus port and a true random number generator core. It holds the generator's run bit, its two sampling counts, the per-oscillator enable mask and the detune word, and drives these straight to the noise logic. In the other direction it takes 128-bit results from the core, keeps one of them, and shows it as four read-only 32-bit words.

Readiness of a result appears in a status bit. Software reads the four words, then writes a one to bit 0 of the status address to release the result. A new result from the core is refused while the current one is still unreleased. The core sees this refusal as a stall, and must keep its result and strobe steady until the stall drops. The sampling counts are locked while the generator runs. Software can therefore read the control word first, find the run bit set, and skip reprogramming.

The bus port is a plain single-cycle port: address, write enable, write data and read data. Read data is combinational from the address. Writes take effect at the next rising clock edge.

Top module: `trng_regs`

## Requirements
- R1: After reset the run bit, both counts, the oscillator mask, the detune word, the ready flag and the held result are all zero, and the core stall output is low.
- R2: When the core strobe is high and no result is ready, the result is stored at the next edge and the ready flag sets. Byte offset 0x0 reads result bits [31:0], 0x4 reads [63:32], 0x8 reads [95:64] and 0xC reads [127:96].
- R3: While the ready flag is set, the stall output is high and the held result does not change, whatever the core presents.
- R4: Offset 0x10 reads the ready flag in bit 0, with all other bits zero. A write there with bit 0 set clears the flag at the next edge. A write there with bit 0 clear changes nothing. After the flag clears, a pending core result is stored one edge later.
- R5: Bit 10 of the control word at 0x14 is the run bit and drives the enable output. The other bits of that word read as zero.
- R6: The configuration word at 0x18 holds the noise-block count in bits [7:0] and the sample-cycle count in bits [23:16]. These drive the count outputs, and the other bits read as zero. A write to this word is taken only when the run bit is 0 at the time of the write. Otherwise the write is dropped.
- R7: Offset 0x20 holds the 24-bit oscillator enable mask in bits [23:0], and offset 0x24 holds the 32-bit detune word. Both drive their outputs and read back as written.
- R8: Offset 0x7C always reads the REVISION parameter, and writes to it have no effect.
- R9: Any other offset reads as zero, including offsets that are not word aligned. Writes to such offsets, and writes to the result words, change no state.
- R10: Read data reflects the addressed register in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| gen_en | output | 1 | Run bit to the noise logic |
| noise_blocks | output | 8 | Noise-block count |
| sample_cycles | output | 8 | Sample-cycle count |
| fro_enable | output | FRO_W | Per-oscillator enable mask |
| fro_detune | output | DET_W | Oscillator detune word |
| core_result | input | RES_W | Result from the core |
| core_valid | input | 1 | Result strobe from the core |
| core_stall | output | 1 | Core must hold its result |

## Verification
Read data for an address is due in the same cycle as that address. A write, or a result strobe, shows on the outputs one rising edge later. A result held back by a set ready flag is stored one edge after the acknowledge edge. The reference model in the bench applies each cycle's inputs at the falling edge, together with the modelled effect of the coming rising edge. At the next falling edge, before new inputs are driven, every output is compared against the model. This way each result is checked exactly one edge after its cause, and read data in the same cycle as its address.

// File: rtl/trng_regs_pkg.sv
package trng_regs_pkg;
    localparam int BUS_W        = 32;
    localparam int CNT_W        = 8;
    localparam int OFS_STAT     = 'h10;
    localparam int OFS_CTL      = 'h14;
    localparam int OFS_CFG      = 'h18;
    localparam int OFS_FRO      = 'h20;
    localparam int OFS_DET      = 'h24;
    localparam int OFS_REV      = 'h7C;
    localparam int CTL_EN_BIT   = 10;
    localparam int CFG_NBLK_LSB = 0;
    localparam int CFG_SCYC_LSB = 16;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] nblk;
        logic [CNT_W-1:0] scyc;
    } ctl_t;
endpackage

// File: rtl/trng_cfg_regs.sv
module trng_cfg_regs
    import trng_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int FRO_W  = 24,
    parameter int DET_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output ctl_t              ctl,
    output logic [FRO_W-1:0]  fro,
    output logic [DET_W-1:0]  det
);
    typedef struct packed {
        ctl_t             ctl;
        logic [FRO_W-1:0] fro;
        logic [DET_W-1:0] det;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (addr == ADDR_W'(OFS_CTL)) begin
                st_d.ctl.en = wdata[CTL_EN_BIT];
            end
            // counts are frozen while the generator runs
            if (addr == ADDR_W'(OFS_CFG) && !st_q.ctl.en) begin
                st_d.ctl.nblk = wdata[CFG_NBLK_LSB +: CNT_W];
                st_d.ctl.scyc = wdata[CFG_SCYC_LSB +: CNT_W];
            end
            if (addr == ADDR_W'(OFS_FRO)) begin
                st_d.fro = wdata[FRO_W-1:0];
            end
            if (addr == ADDR_W'(OFS_DET)) begin
                st_d.det = wdata[DET_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl = st_q.ctl;
    assign fro = st_q.fro;
    assign det = st_q.det;
endmodule

// File: rtl/trng_result_hold.sv
module trng_result_hold #(
    parameter int RES_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [RES_W-1:0] result,
    input  logic             ack,
    output logic             ready,
    output logic [RES_W-1:0] held,
    output logic             stall
);
    typedef struct packed {
        logic             rdy;
        logic [RES_W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid && !st_q.rdy) begin
            st_d.res = result;
            st_d.rdy = 1'b1;
        end else if (ack) begin
            st_d.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = st_q.rdy;
    assign held  = st_q.res;
    assign stall = st_q.rdy;
endmodule

// File: rtl/trng_rd_mux.sv
module trng_rd_mux
    import trng_regs_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          RES_W    = 128,
    parameter int          FRO_W    = 24,
    parameter int          DET_W    = 32,
    parameter logic [31:0] REVISION = 32'h0132_00A5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ready,
    input  logic [RES_W-1:0]  held,
    input  ctl_t              ctl,
    input  logic [FRO_W-1:0]  fro,
    input  logic [DET_W-1:0]  det,
    output logic [BUS_W-1:0]  rdata
);
    localparam int WORDS = RES_W / BUS_W;

    logic [BUS_W-1:0] word [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign word[g] = held[g*BUS_W +: BUS_W];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (addr == ADDR_W'(k * 4)) rdata = word[k];
        end
        if (addr == ADDR_W'(OFS_STAT)) rdata[0] = ready;
        if (addr == ADDR_W'(OFS_CTL))  rdata[CTL_EN_BIT] = ctl.en;
        if (addr == ADDR_W'(OFS_CFG)) begin
            rdata[CFG_NBLK_LSB +: CNT_W] = ctl.nblk;
            rdata[CFG_SCYC_LSB +: CNT_W] = ctl.scyc;
        end
        if (addr == ADDR_W'(OFS_FRO))  rdata[FRO_W-1:0] = fro;
        if (addr == ADDR_W'(OFS_DET))  rdata[DET_W-1:0] = det;
        if (addr == ADDR_W'(OFS_REV))  rdata = REVISION;
    end
endmodule

// File: rtl/trng_regs.sv
module trng_regs
    import trng_regs_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          RES_W    = 128,
    parameter int          FRO_W    = 24,
    parameter int          DET_W    = 32,
    parameter logic [31:0] REVISION = 32'h0132_00A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              gen_en,
    output logic [7:0]        noise_blocks,
    output logic [7:0]        sample_cycles,
    output logic [FRO_W-1:0]  fro_enable,
    output logic [DET_W-1:0]  fro_detune,
    input  logic [RES_W-1:0]  core_result,
    input  logic              core_valid,
    output logic              core_stall
);
    ctl_t             ctl_w;
    logic             ready_w;
    logic [RES_W-1:0] res_w;
    logic             ack_w;

    assign ack_w = bus_we && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[0];

    trng_cfg_regs #(.ADDR_W(ADDR_W), .FRO_W(FRO_W), .DET_W(DET_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .ctl   (ctl_w),
        .fro   (fro_enable),
        .det   (fro_detune)
    );

    trng_result_hold #(.RES_W(RES_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (core_valid),
        .result (core_result),
        .ack    (ack_w),
        .ready  (ready_w),
        .held   (res_w),
        .stall  (core_stall)
    );

    trng_rd_mux #(.ADDR_W(ADDR_W), .RES_W(RES_W), .FRO_W(FRO_W), .DET_W(DET_W),
                  .REVISION(REVISION)) u_rd (
        .addr  (bus_addr),
        .ready (ready_w),
        .held  (res_w),
        .ctl   (ctl_w),
        .fro   (fro_enable),
        .det   (fro_detune),
        .rdata (bus_rdata)
    );

    assign gen_en        = ctl_w.en;
    assign noise_blocks  = ctl_w.nblk;
    assign sample_cycles = ctl_w.scyc;
endmodule

// File: rtl/trng_regs_chk.sv
module trng_regs_chk
    import trng_regs_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          RES_W    = 128,
    parameter logic [31:0] REVISION = 32'h0132_00A5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              ack_bit,
    input logic              en_bit,
    input logic [31:0]       bus_rdata,
    input logic              gen_en,
    input logic [7:0]        noise_blocks,
    input logic [7:0]        sample_cycles,
    input logic              core_valid,
    input logic              core_stall,
    input logic [RES_W-1:0]  held
);
    logic ack_seen;
    logic mapped;

    assign ack_seen = bus_we && bus_addr == ADDR_W'(OFS_STAT) && ack_bit;
    assign mapped   = bus_addr == ADDR_W'(0)  || bus_addr == ADDR_W'(4)  ||
                      bus_addr == ADDR_W'(8)  || bus_addr == ADDR_W'(12) ||
                      bus_addr == ADDR_W'(OFS_STAT) || bus_addr == ADDR_W'(OFS_CTL) ||
                      bus_addr == ADDR_W'(OFS_CFG)  || bus_addr == ADDR_W'(OFS_FRO) ||
                      bus_addr == ADDR_W'(OFS_DET)  || bus_addr == ADDR_W'(OFS_REV);

    // R2
    capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && !core_stall) |=> core_stall);

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |=> $stable(held));

    // R3
    stall_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_stall && !ack_seen) |=> core_stall);

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_seen && core_stall) |=> !core_stall);

    // R5
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_CTL)) |=> gen_en == $past(en_bit));

    // R6
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && bus_we && bus_addr == ADDR_W'(OFS_CFG))
        |=> ($stable(noise_blocks) && $stable(sample_cycles)));

    // R8
    rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_REV)) |-> bus_rdata == REVISION);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == 32'h0);
endmodule

bind trng_regs trng_regs_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W), .REVISION(REVISION)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .ack_bit       (bus_wdata[0]),
    .en_bit        (bus_wdata[10]),
    .bus_rdata     (bus_rdata),
    .gen_en        (gen_en),
    .noise_blocks  (noise_blocks),
    .sample_cycles (sample_cycles),
    .core_valid    (core_valid),
    .core_stall    (core_stall),
    .held          (res_w)
);

// File: tb/trng_regs_test.sv
module trng_regs_test;
    localparam logic [31:0] REV = 32'h0132_00A5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   addr = '0;
    logic         we = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         gen_en;
    logic [7:0]   nblk, scyc;
    logic [23:0]  fro;
    logic [31:0]  det;
    logic [127:0] cres = '0;
    logic         cv = 1'b0;
    logic         stall;

    int total = 0, fails = 0, cycles = 0;
    bit done = 0;

    // behavioural model state
    bit          m_rdy = 0, m_en = 0;
    bit [127:0]  m_res = '0;
    bit [7:0]    m_nb = 0, m_sc = 0;
    bit [23:0]   m_fro = 0;
    bit [31:0]   m_det = 0;

    trng_regs #(.REVISION(REV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .gen_en(gen_en), .noise_blocks(nblk), .sample_cycles(scyc),
        .fro_enable(fro), .fro_detune(det), .core_result(cres), .core_valid(cv),
        .core_stall(stall)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] model_read(input bit [7:0] a);
        case (a)
            8'h00: return m_res[31:0];
            8'h04: return m_res[63:32];
            8'h08: return m_res[95:64];
            8'h0C: return m_res[127:96];
            8'h10: return {31'b0, m_rdy};
            8'h14: return m_en ? 32'h400 : 32'h0;
            8'h18: return {8'h0, m_sc, 8'h0, m_nb};
            8'h20: return {8'h0, m_fro};
            8'h24: return m_det;
            8'h7C: return REV;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input bit [7:0] a);
        if (a < 8'h10 && a[1:0] == 2'b00) return "R2";
        case (a)
            8'h10: return "R4";
            8'h14: return "R5";
            8'h18: return "R6";
            8'h20, 8'h24: return "R7";
            8'h7C: return "R8";
            default: return "R9";
        endcase
    endfunction

    // R10: read data compared in the same cycle as its address
    task automatic compare_all();
        bit [31:0] e;
        e = model_read(addr);
        chk(rdata === e, {tag_of(addr), "/R10 rdata"}, rdata, e);
        chk(gen_en === m_en, "R5 gen_en", gen_en, m_en);
        chk(nblk === m_nb && scyc === m_sc, "R6 counts", {nblk, scyc}, {m_nb, m_sc});
        chk(fro === m_fro && det === m_det, "R7 fro", {fro, det}, {m_fro, m_det});
        chk(stall === m_rdy, "R3 stall", stall, m_rdy);
    endtask

    // effect of the coming rising edge
    task automatic step();
        bit ack;
        ack = we && addr == 8'h10 && wdata[0];
        if (we && addr == 8'h18 && !m_en) begin
            m_nb = wdata[7:0];
            m_sc = wdata[23:16];
        end
        if (we && addr == 8'h14) m_en = wdata[10];
        if (we && addr == 8'h20) m_fro = wdata[23:0];
        if (we && addr == 8'h24) m_det = wdata;
        if (cv && !m_rdy) begin
            m_res = cres;
            m_rdy = 1;
        end else if (ack) begin
            m_rdy = 0;
        end
    endtask

    task automatic cyc(input bit [7:0] a, input bit w, input bit [31:0] d,
                       input bit v, input bit [127:0] r);
        @(negedge clk);
        compare_all();
        addr = a; we = w; wdata = d; cv = v; cres = r;
        step();
    endtask

    task automatic rd(input bit [7:0] a);
        cyc(a, 0, 0, 0, 0);
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        cyc(a, 1, d, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            total++;
            $display("FAIL R1 watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    localparam bit [127:0] RA = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    localparam bit [127:0] RB = 128'hDEADBEEF_01234567_89ABCDEF_FEDCBA98;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(gen_en === 0 && stall === 0 && rdata === 0, "R1 reset", {gen_en, stall, rdata}, 0);
        chk(nblk === 0 && scyc === 0 && fro === 0 && det === 0, "R1 reset regs",
            {nblk, scyc, fro, det}, 0);
        // R8, R9: sweep of read offsets
        for (int a = 0; a <= 8'h80; a += 2) rd(8'(a));
        // R6 config accepted while stopped, R7 oscillator words
        wr(8'h18, 32'hFF22_AA05);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'h0000_0000);
        wr(8'h24, 32'h5A5A_C3C3);
        rd(8'h18); rd(8'h20); rd(8'h24);
        // R5 start generator, other control bits dropped
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14);
        // R6 config locked while running
        wr(8'h18, 32'h0011_0033);
        rd(8'h18);
        // R2 first result
        cyc(8'h00, 0, 0, 1, RA);
        cyc(8'h00, 0, 0, 0, 0);
        rd(8'h04); rd(8'h08); rd(8'h0C); rd(8'h10);
        // R3 second result offered while ready: stalled
        cyc(8'h00, 0, 0, 1, RB);
        cyc(8'h0C, 0, 0, 1, RB);
        cyc(8'h10, 0, 0, 1, RB);
        // R4 ack with bit 0 clear has no effect
        cyc(8'h10, 1, 32'hFFFF_FFFE, 1, RB);
        cyc(8'h10, 0, 0, 1, RB);
        // R9 writes to result words, revision and unmapped offsets
        cyc(8'h00, 1, 32'h1234_5678, 1, RB);
        cyc(8'h7C, 1, 32'h0, 1, RB);
        cyc(8'h40, 1, 32'hFFFF_FFFF, 1, RB);
        cyc(8'h1C, 1, 32'hFFFF_FFFF, 1, RB);
        cyc(8'h00, 0, 0, 1, RB);
        // R4 ack releases; pending result loads one edge later
        cyc(8'h10, 1, 32'h1, 1, RB);
        cyc(8'h10, 0, 0, 1, RB);
        cyc(8'h00, 0, 0, 0, 0);
        rd(8'h04); rd(8'h08); rd(8'h0C);
        // R4 ack with nothing pending
        wr(8'h10, 32'h1);
        rd(8'h10);
        // R4 ack and strobe in the same cycle while not ready: result taken
        cyc(8'h10, 1, 32'h1, 1, RA);
        rd(8'h00);
        wr(8'h10, 32'h1);
        // R5/R6 stop, then config accepted again
        wr(8'h14, 32'h0);
        wr(8'h18, 32'h0011_0033);
        rd(8'h18); rd(8'h14); rd(8'h7C); rd(8'h7E);
        rd(8'h00);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule